// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Register Port

This block is a serial peripheral interface controller that sits on a small 8-bit register bus. Software sees three byte registers: one for configuration, one for the completion and collision flags, and one for data. The controller can run as the bus master, generating the serial clock and select, or as a slave that follows an external clock and select. Bit order, clock idle level, sampling edge and, in master mode, the serial clock rate are set in the configuration register.

A master transfer starts when the data register is written while the controller is enabled, in master mode and idle. A slave transfer starts when the external select falls. When eight bits have been exchanged, the received byte replaces the data register and the completion flag rises. An interrupt output follows that flag, gated by a local enable bit and an external enable input. Writing the data register during a transfer is refused and raises the collision flag. Both flags clear only through a two-step sequence: a status read that sees a flag set, then any read or write of the data register.

In slave mode the external clock, select and data input pass through a two-stage synchroniser. The external clock's half-period must therefore be at least about five system clock cycles, and the select must return high between bytes.

Top module: `spi_port`

## Requirements
- R1: After reset the configuration register reads 04h, the status register reads 00h, `irq` is 0, `ss_n_o` is 1 and `sck_o` is 0.
- R2: Register addresses are D5h for configuration, AAh for status and 86h for data. Configuration bits from 7 down to 0 are interrupt enable, controller enable, LSB-first, master, clock polarity, clock phase, rate bit 1 and rate bit 0. All eight bits read back as written.
- R3: In master mode every half-period of `sck_o` lasts 2, 8, 32 or 64 system clock cycles for rate codes 0, 1, 2 and 3. The same half-period separates the fall of `ss_n_o` from the first clock edge, and the last clock edge from the rise of `ss_n_o`.
- R4: With LSB-first set to 1, bit 0 is shifted first on both the outgoing and incoming lines. With LSB-first set to 0, bit 7 is shifted first.
- R5: While no transfer runs, `sck_o` rests at the clock polarity bit.
- R6: With clock phase 0, data is sampled on the leading clock edge (the edge that leaves the idle level) and changed on the trailing edge, and the first bit is valid when select falls. With clock phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R7: A master transfer holds `ss_n_o` low for exactly 16 clock edges. It then releases `ss_n_o`, loads the received byte into the data register and sets status bit 7 (completion).
- R8: A data-register write during a transfer leaves the outgoing byte unchanged and sets status bit 6 (collision).
- R9: Status bits 7 and 6 clear only when a data-register read or write follows a status read that saw either flag set. A data access with no such status read first leaves them set.
- R10: `irq` is 1 one cycle after the completion flag, the interrupt enable bit and `ser_int_en` are all 1, and is 0 otherwise.
- R11: In slave mode the controller exchanges a byte on `sck_i` while `ss_n_i` is low. It sends the previously written data byte on `miso_o` and stores the `mosi_i` byte with the completion flag set. The rate bits have no effect.
- R12: With the controller enable bit at 0, a data write only stores the byte: no transfer starts and `ss_n_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| ser_int_en | input | 1 | External serial interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| ss_n_i | input | 1 | Active-low select from an external master |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| mosi_i | input | 1 | Serial data received in slave mode |
| mosi_o | output | 1 | Serial data sent in master mode |
| miso_i | input | 1 | Serial data received in master mode |
| miso_o | output | 1 | Serial data sent in slave mode |

## Verification
The assertions watch properties that must hold on every cycle: the clock idles at the polarity level, select stays high outside a transfer, the divider count stays under the chosen half-period, a busy data write always raises the collision flag, the completion flag falls only after a data access that followed an arming status read, and the interrupt only follows its three enabling conditions. The serial exchange itself cannot be judged from a single cycle. This covers bit order under all four clock modes, the half-period length across rate codes, the edge count inside select, slave exchange through the synchroniser and the refusal of a mid-transfer write. The bench shows these through a serial partner model that records and drives bits and compares whole bytes and edge timing.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       irq_en;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h04;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W     = 7,
  parameter int BASE_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt;

  always_comb begin
    case (rate)
      2'd0:    half = DIV_W'(BASE_HALF);
      2'd1:    half = DIV_W'(BASE_HALF * 4);
      2'd2:    half = DIV_W'(BASE_HALF * 16);
      default: half = DIV_W'(BASE_HALF * 32);
    endcase
  end

  assign tick = run && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end

  // R3: divider never runs past the selected half-period
  assert_div_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < half));

endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               W       = 3,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int CW = STAGES * W;

  logic [CW-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[CW-W-1:0], d};
  end

  assign q = chain[CW-1 -: W];

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'('hD5),
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('hAA),
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'('h86),
  parameter int              SYNC_STAGES = 2,
  parameter int              DIV_W       = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              ser_int_en,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o
);

  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam int CW = IW + 1;
  localparam int EW = IW + 2;
  localparam logic [CW-1:0] BITS  = CW'(DW);
  localparam logic [EW-1:0] EDGES = EW'(2 * DW);

  function automatic logic [IW-1:0] pos(input logic [CW-1:0] c, input logic lsb);
    return lsb ? c[IW-1:0] : (IW'(DW - 1) - c[IW-1:0]);
  endfunction

  spi_cfg_t       cfg;
  logic           spif, wcol, armed, act, out_bit;
  logic [EW-1:0]  ecnt;
  logic [CW-1:0]  scnt, lcnt;
  logic [DW-1:0]  dreg, tx, rx;
  logic           sck_d, ss_d;
  logic [2:0]     sync_q;
  logic           sck_s, ss_s, mosi_s;
  logic           tick;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sck_i, ss_n_i, mosi_i}), .q(sync_q)
  );
  assign {sck_s, ss_s, mosi_s} = sync_q;

  spi_rate_gen #(.DIV_W(DIV_W), .BASE_HALF(2)) u_rate (
    .clk(clk), .rst(rst), .run(act && cfg.master), .rate(cfg.rate), .tick(tick)
  );

  logic acc_data, wr_data, rd_stat, mst_go, slv_go, go;
  logic m_edge, m_done, s_edge, s_done, s_abort, done, abort;
  logic lead, ev, smp_ev, lnc_ev, in_bit;
  logic [DW-1:0] src;

  always_comb begin
    acc_data = (bus_rd || bus_wr) && (bus_addr == DATA_ADDR);
    wr_data  = bus_wr && (bus_addr == DATA_ADDR);
    rd_stat  = bus_rd && (bus_addr == STAT_ADDR);
    mst_go   = wr_data && cfg.en && cfg.master && !act;
    slv_go   = ss_d && !ss_s && cfg.en && !cfg.master && !act;
    go       = mst_go || slv_go;
    src      = mst_go ? bus_wdata : dreg;
    m_edge   = act && cfg.master && tick && (ecnt < EDGES);
    m_done   = act && cfg.master && tick && (ecnt == EDGES);
    s_edge   = act && !cfg.master && !ss_s && (sck_s != sck_d);
    s_done   = act && !cfg.master && (scnt == BITS);
    s_abort  = act && !cfg.master && ss_s && !s_done;
    done     = m_done || s_done;
    abort    = act && (!cfg.en || s_abort);
    lead     = cfg.master ? !ecnt[0] : (sck_s != cfg.cpol);
    ev       = m_edge || s_edge;
    smp_ev   = ev && (lead ^ cfg.cpha);
    lnc_ev   = ev && !(lead ^ cfg.cpha);
    in_bit   = cfg.master ? miso_i : mosi_s;
  end

  // control, flags, bus read and serial sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= spi_cfg_t'(CFG_RESET);
      spif      <= 1'b0;
      wcol      <= 1'b0;
      armed     <= 1'b0;
      act       <= 1'b0;
      ss_n_o    <= 1'b1;
      sck_o     <= 1'b0;
      ecnt      <= '0;
      scnt      <= '0;
      lcnt      <= '0;
      out_bit   <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
      sck_d     <= 1'b0;
      ss_d      <= 1'b1;
    end else begin
      sck_d <= sck_s;
      ss_d  <= ss_s;
      if (bus_wr && bus_addr == CFG_ADDR) cfg <= spi_cfg_t'(bus_wdata);

      if (go) begin
        act    <= 1'b1;
        ecnt   <= '0;
        scnt   <= '0;
        ss_n_o <= !mst_go;
        if (!cfg.cpha) begin
          out_bit <= src[pos('0, cfg.lsb_first)];
          lcnt    <= CW'(1);
        end else begin
          lcnt    <= '0;
        end
      end else if (done || abort) begin
        act    <= 1'b0;
        ss_n_o <= 1'b1;
      end else begin
        if (m_edge) begin
          sck_o <= !sck_o;
          ecnt  <= ecnt + EW'(1);
        end
        if (smp_ev && scnt < BITS) scnt <= scnt + CW'(1);
        if (lnc_ev && lcnt < BITS) begin
          out_bit <= tx[pos(lcnt, cfg.lsb_first)];
          lcnt    <= lcnt + CW'(1);
        end
      end
      if (!act && !go) sck_o <= cfg.cpol;

      if (acc_data && armed) begin
        spif  <= 1'b0;
        wcol  <= 1'b0;
        armed <= 1'b0;
      end
      if (rd_stat && (spif || wcol)) armed <= 1'b1;
      if (done) spif <= 1'b1;
      if (wr_data && act) wcol <= 1'b1;

      irq <= spif && cfg.irq_en && ser_int_en;

      if (bus_rd) begin
        if (bus_addr == CFG_ADDR)       bus_rdata <= cfg;
        else if (bus_addr == STAT_ADDR) bus_rdata <= {spif, wcol, 6'b0};
        else if (bus_addr == DATA_ADDR) bus_rdata <= dreg;
        else                            bus_rdata <= '0;
      end else begin
        bus_rdata <= '0;
      end
    end
  end

  // data path: contents survive reset
  always_ff @(posedge clk) begin
    if (go) tx <= src;
    if (smp_ev && scnt < BITS) rx[pos(scnt, cfg.lsb_first)] <= in_bit;
    if (wr_data && !act) dreg <= bus_wdata;
    else if (done)       dreg <= rx;
  end

  assign mosi_o = out_bit;
  assign miso_o = out_bit;

  // R5: clock rests at polarity level once idle has settled
  assert_idle_sck_R5: assert property (@(posedge clk) disable iff (rst)
    (!act && !$past(act) && $stable(cfg.cpol)) |-> (sck_o == cfg.cpol));

  // R7: select only asserted during a transfer
  assert_ss_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !act |-> ss_n_o);

  // R8: refused write always reports a collision
  assert_wcol_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_data && act) |=> wcol);

  // R9: completion flag drops only after an armed data access
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(spif) |-> $past(armed && acc_data));

  // R10: interrupt only follows its three enabling conditions
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(spif && cfg.irq_en && ser_int_en));

endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic ser_int_en = 1'b0;
  logic irq;
  logic sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
  logic sck_o, ss_n_o, mosi_o, miso_o;

  always #5 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ser_int_en(ser_int_en), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .ss_n_i(ss_n_i), .ss_n_o(ss_n_o),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o)
  );

  localparam logic [7:0] A_CFG = 8'hD5, A_STAT = 8'hAA, A_DATA = 8'h86;

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bidx(input int c, input bit lsb);
    return lsb ? c : 7 - c;
  endfunction

  function automatic int half_of(input logic [1:0] r);
    case (r)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // serial partner model for master mode
  bit cpol_b, cpha_b, lsb_b;
  int half_b = 2;
  logic [7:0] sbyte = '0, got_m = '0;
  int sidx, lidx, edges, end_edges, per_bad, cyc = 0, last_ev;
  bit prev_sck = 1'b0, prev_ss = 1'b1, done_seen = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (prev_ss && !ss_n_o) begin
      sidx = 0; edges = 0; per_bad = 0; last_ev = cyc;
      if (!cpha_b) begin miso_i = sbyte[bidx(0, lsb_b)]; lidx = 1; end
      else lidx = 0;
    end else if (!ss_n_o && sck_o != prev_sck) begin
      edges++;
      if (cyc - last_ev != half_b) per_bad++;
      last_ev = cyc;
      if ((sck_o != cpol_b) ^ cpha_b) begin
        if (sidx < 8) got_m[bidx(sidx, lsb_b)] = mosi_o;
        sidx++;
      end else if (lidx < 8) begin
        miso_i = sbyte[bidx(lidx, lsb_b)];
        lidx++;
      end
    end
    if (!prev_ss && ss_n_o) begin
      end_edges = edges;
      if (cyc - last_ev != half_b) per_bad++;
      done_seen = 1'b1;
    end
    prev_sck = sck_o;
    prev_ss  = ss_n_o;
  end

  task automatic master_xfer(input bit lsb, input bit cpol, input bit cpha,
                             input logic [1:0] rate, input logic [7:0] txb,
                             input logic [7:0] sb, input bit collide);
    logic [7:0] d;
    reg_wr(A_CFG, {1'b0, 1'b1, lsb, 1'b1, cpol, cpha, rate});
    cpol_b = cpol; cpha_b = cpha; lsb_b = lsb; half_b = half_of(rate);
    repeat (3) @(negedge clk);
    chk("R5 idle sck level", sck_o, cpol);
    sbyte = sb; done_seen = 1'b0;
    reg_wr(A_DATA, txb);
    if (collide) begin
      repeat (4) @(negedge clk);
      reg_wr(A_DATA, ~txb);
    end
    for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R4/R6 byte seen on mosi", got_m, txb);
    chk("R3 half-period spacing errors", per_bad, 0);
    chk("R7 edges inside select", end_edges, 16);
    reg_rd(A_STAT, d);
    chk(collide ? "R8 status with collision" : "R7 status after transfer", d,
        collide ? 8'hC0 : 8'h80);
    reg_rd(A_DATA, d);
    chk("R7/R4 received byte in data reg", d, sb);
    reg_rd(A_STAT, d);
    chk("R9 flags cleared by sequence", d, 8'h00);
  endtask

  task automatic slave_xfer(input bit lsb, input bit cpol, input bit cpha,
                            input logic [1:0] rate, input logic [7:0] mb,
                            input logic [7:0] pre);
    logic [7:0] d, got;
    int si, li;
    reg_wr(A_CFG, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, rate});
    sck_i = cpol; ss_n_i = 1'b1;
    reg_wr(A_DATA, pre);
    repeat (6) @(negedge clk);
    got = '0; si = 0; li = 0;
    ss_n_i = 1'b0;
    if (!cpha) begin mosi_i = mb[bidx(0, lsb)]; li = 1; end
    repeat (8) @(negedge clk);
    for (int e = 0; e < 16; e++) begin
      sck_i = ~sck_i;
      if ((e % 2 == 0) ^ cpha) begin
        got[bidx(si, lsb)] = miso_o; si++;
      end else if (li < 8) begin
        mosi_i = mb[bidx(li, lsb)]; li++;
      end
      repeat (8) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 slave byte sent on miso", got, pre);
    reg_rd(A_STAT, d);
    chk("R11 slave completion flag", d, 8'h80);
    reg_rd(A_DATA, d);
    chk("R11 slave received byte", d, mb);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seed;
    int bad;
    seed = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R1 reset ss_n_o", ss_n_o, 1'b1);
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset sck_o", sck_o, 1'b0);
    reg_rd(A_CFG, d);  chk("R1 reset config", d, 8'h04);
    reg_rd(A_STAT, d); chk("R1 reset status", d, 8'h00);

    reg_wr(A_CFG, 8'hA7); reg_rd(A_CFG, d); chk("R2 config readback", d, 8'hA7);
    reg_wr(A_CFG, 8'h58); reg_rd(A_CFG, d); chk("R2 config readback", d, 8'h58);

    // R12: disabled controller only stores data
    reg_wr(A_CFG, 8'h10);
    reg_wr(A_DATA, 8'h33);
    bad = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!ss_n_o) bad++; end
    chk("R12 no select while disabled", bad, 0);
    reg_rd(A_STAT, d); chk("R12 no flag while disabled", d, 8'h00);
    reg_rd(A_DATA, d); chk("R12 data stored", d, 8'h33);

    // directed: all four clock modes, both orders
    master_xfer(1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b1, 1'b0, 1'b1, 2'd1, 8'h81, 8'h7E, 1'b0);
    master_xfer(1'b0, 1'b1, 1'b0, 2'd2, 8'h0F, 8'hF1, 1'b0);
    master_xfer(1'b1, 1'b1, 1'b1, 2'd3, 8'hC3, 8'h96, 1'b0);
    // R8: collision during a transfer
    master_xfer(1'b0, 1'b0, 1'b1, 2'd1, 8'h6D, 8'h12, 1'b1);

    // R9 and R10: flag handling and interrupt gating
    reg_wr(A_CFG, 8'hD0);
    cpol_b = 0; cpha_b = 0; lsb_b = 0; half_b = 2; sbyte = 8'h55; done_seen = 0;
    reg_wr(A_DATA, 8'hAA);
    for (int i = 0; i < 200 && !done_seen; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R10 irq low with external enable off", irq, 1'b0);
    ser_int_en = 1'b1; repeat (2) @(negedge clk);
    chk("R10 irq high with all enables", irq, 1'b1);
    reg_wr(A_CFG, 8'h50); repeat (2) @(negedge clk);
    chk("R10 irq low with local enable off", irq, 1'b0);
    reg_wr(A_CFG, 8'hD0); repeat (2) @(negedge clk);
    reg_rd(A_DATA, d); chk("R7 data reg after transfer", d, 8'h55);
    reg_rd(A_STAT, d); chk("R9 data access without arming keeps flag", d, 8'h80);
    reg_rd(A_DATA, d);
    repeat (2) @(negedge clk);
    chk("R10 irq drops after flag clear", irq, 1'b0);
    reg_rd(A_STAT, d); chk("R9 flag cleared after armed access", d, 8'h00);
    ser_int_en = 1'b0;

    // constrained random master transfers
    for (int k = 0; k < 10; k++) begin
      logic [1:0] r;
      r = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      master_xfer(1'($urandom), 1'($urandom), 1'($urandom), r,
                  8'($urandom), 8'($urandom), 1'b0);
    end

    // slave mode, rate bits varied
    slave_xfer(1'b0, 1'b0, 1'b0, 2'd3, 8'hB4, 8'h2D);
    slave_xfer(1'b1, 1'b1, 1'b1, 2'd0, 8'h1E, 8'hE7);
    for (int k = 0; k < 4; k++)
      slave_xfer(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                 8'($urandom), 8'($urandom));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule